// File: doc/BRIEF.md
# Frame-Timed Instruction Sequencer

A small programmable timing engine for one radio frame. A frame is 5000 quarter-bit ticks. The host writes 16-bit instruction words into a 64-word local program store through a push port, rewinds the pointers, and sets the run enable. The sequencer then steps through the program against a frame counter that advances on a quarter-bit tick strobe. It can hold until an absolute position in the frame or pause for a number of ticks. It can load an offset and a synchro register, and it can write bytes into a small control register file. Two bytes of that file drive an actuator output word. A write to a dedicated address raises an interrupt request toward the DSP.

The top three bits of each word select the operation: 0 halt, 1 hold-until-time, 2 load offset, 3 load synchro, 4 register write, 5 tick pause, 6 and 7 no-operation. Bits 12:0 hold a 13-bit operand. For the register write, the data byte is in bits 12:5 and the 5-bit target address is in bits 4:0. A frame interrupt pulse toward the MCU and a DSP interrupt pending flag are produced at each counter wrap, each one gated by its own enable. The host can also force the DSP flag and clear it.

The controller has five states. IDLE is entered on reset, on a halt, or when the enable drops. FETCH latches the word at the fetch pointer. EXEC decodes and acts. AT_HOLD waits for the frame position. TICK_HOLD counts down pause ticks. The transitions are: IDLE→FETCH when enabled; FETCH→EXEC always; EXEC→IDLE on halt; EXEC→AT_HOLD on an unmatched hold; EXEC→TICK_HOLD on a non-zero pause; EXEC→FETCH otherwise; AT_HOLD→FETCH on a match; TICK_HOLD→FETCH on the last tick; any state→IDLE when the run enable is clear.

Top module: `frame_seq`

## Requirements
- R1: After reset, `idle`=1, `frame_count`=0, `offset_val`=0, `synchro_val`=0, `act_out`=0, `dsp_irq_pend`=0 and `mcu_frame_irq`=0.
- R2: `frame_count` advances by one on each clock with `clk_en`=1 and `qtick`=1, and wraps from 4999 to 0. While `clk_en`=0 the counter and the sequencer hold their state.
- R3: Opcode 2 loads operand bits 12:0 into `offset_val`. Opcode 3 loads them into `synchro_val`.
- R4: Opcode 4 writes bits 12:5 into control register bits 4:0 (addresses 0..15). `rd_data` returns the register at `rd_addr`. `act_out` is {register 7, register 6}.
- R5: A write to address 0x10 with data bit 0 set raises `dsp_irq_pend`. With bit 0 clear it has no effect. Writes to 0x11..0x1F change nothing, and those addresses read as 0.
- R6: Opcode 1 with operand T holds until (frame_count + offset) mod 5000 = T. With `qtick` high every cycle, the next instruction's effect is visible when `frame_count` = (T − offset + 3) mod 5000.
- R7: Opcode 5 with operand N pauses for N ticks. With `qtick` high every cycle, two register writes around it take effect N+4 cycles apart.
- R8: Opcode 0 clears the run enable and `idle` goes to 1. Execution stays stopped until `en_set`, then resumes at the following word.
- R9: Opcodes 6 and 7 change no register, no flag and no output.
- R10: `rewind` returns both the push pointer and the fetch pointer to word 0, so the next run starts from the base of the program store.
- R11: At a wrap, `mcu_frame_irq` pulses for one cycle (with `frame_count`=0) when `mcu_irq_en`=1. `dsp_irq_pend` is set one cycle later when `dsp_irq_en`=1. `dsp_irq_force` sets the flag. The flag holds until `dsp_irq_ack`.
- R12: `soft_rst` restores the R1 state and both pointers but keeps the program store, so a new `en_set` re-runs the stored program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous host reset of the sequencer |
| clk_en | input | 1 | Advance enable for counter and sequencer |
| qtick | input | 1 | Quarter-bit tick strobe |
| push_valid | input | 1 | Write `push_word` at the push pointer |
| push_word | input | 16 | Instruction word to store |
| rewind | input | 1 | Reset push and fetch pointers to 0 |
| en_set | input | 1 | Set run enable |
| en_clr | input | 1 | Clear run enable |
| mcu_irq_en | input | 1 | Frame interrupt enable toward the MCU |
| dsp_irq_en | input | 1 | Frame interrupt enable toward the DSP |
| dsp_irq_force | input | 1 | Force the DSP interrupt flag |
| dsp_irq_ack | input | 1 | DSP-side clear of the flag |
| rd_addr | input | 5 | Control register readback address |
| rd_data | output | 8 | Control register readback data |
| frame_count | output | 13 | Quarter-bit position in the frame |
| offset_val | output | 13 | Offset register |
| synchro_val | output | 13 | Synchro register |
| act_out | output | 16 | Actuator control word |
| dsp_irq_pend | output | 1 | DSP interrupt pending |
| mcu_frame_irq | output | 1 | MCU frame interrupt pulse |
| idle | output | 1 | Sequencer stopped |

## Verification
A wrong state or a wrong fetch pointer shows up at the next register write. The actuator word or the offset takes a value from the wrong word, or it changes a cycle early or late. The bench therefore times every write against `frame_count` or against the cycle count. A bad hold comparison or a bad tick counter moves the release point by a fixed number of cycles, so sweeps of times, offsets and pause lengths expose it within one frame. A flag that leaks shows at `dsp_irq_pend` on the cycle after the stimulus.

// File: rtl/fs_pkg.sv
package fs_pkg;
    localparam int INSTR_W  = 16;
    localparam int OPC_LSB  = 13;
    localparam int FIELD_W  = 13;
    localparam int DATA_LSB = 5;
    localparam int DATA_W   = 8;
    localparam int RADDR_W  = 5;
    localparam logic [RADDR_W-1:0] DIRQ_ADDR = 5'h10;

    typedef enum logic [2:0] {
        OP_HALT   = 3'd0,
        OP_AT     = 3'd1,
        OP_OFFSET = 3'd2,
        OP_SYNC   = 3'd3,
        OP_MOVE   = 3'd4,
        OP_PAUSE  = 3'd5,
        OP_NOP6   = 3'd6,
        OP_NOP7   = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_AT_HOLD,
        ST_TICK_HOLD
    } state_e;
endpackage

// File: rtl/fs_frame_ctr.sv
module fs_frame_ctr #(
    parameter int FRAME_LEN = 5000,
    parameter int CW        = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            wrap <= 1'b0;
        end else if (clr) begin
            cnt  <= '0;
            wrap <= 1'b0;
        end else begin
            wrap <= 1'b0;
            if (adv) begin
                if (cnt == LAST) begin
                    cnt  <= '0;
                    wrap <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && cnt == LAST) |=> (cnt == '0 && wrap));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(cnt));
endmodule

// File: rtl/fs_imem.sv
module fs_imem #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fs_regfile.sv
module fs_regfile #(
    parameter int NREG   = 16,
    parameter int DW     = 8,
    parameter int AW     = 5,
    parameter int ACT_LO = 6,
    parameter int ACT_HI = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic [2*DW-1:0] act_out
);
    localparam int IW = $clog2(NREG);

    logic [NREG-1:0][DW-1:0] regs_flat;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q <= '0;
            else if (clr)                        q <= '0;
            else if (we && waddr == AW'(i))      q <= wdata;
        end
        assign regs_flat[i] = q;
    end

    assign rdata   = (raddr < AW'(NREG)) ? regs_flat[raddr[IW-1:0]] : '0;
    assign act_out = {regs_flat[ACT_HI], regs_flat[ACT_LO]};

    assert_ignored_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr && waddr >= AW'(NREG)) |=> $stable(regs_flat));
endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import fs_pkg::*;
#(
    parameter int FRAME_LEN  = 5000,
    parameter int IMEM_DEPTH = 64,
    parameter int NUM_REGS   = 16,
    parameter int ACT_LO     = 6,
    parameter int ACT_HI     = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        clk_en,
    input  logic        qtick,
    input  logic        push_valid,
    input  logic [15:0] push_word,
    input  logic        rewind,
    input  logic        en_set,
    input  logic        en_clr,
    input  logic        mcu_irq_en,
    input  logic        dsp_irq_en,
    input  logic        dsp_irq_force,
    input  logic        dsp_irq_ack,
    input  logic [4:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic [12:0] frame_count,
    output logic [12:0] offset_val,
    output logic [12:0] synchro_val,
    output logic [15:0] act_out,
    output logic        dsp_irq_pend,
    output logic        mcu_frame_irq,
    output logic        idle
);
    localparam int CW = $clog2(FRAME_LEN);
    localparam int PW = $clog2(IMEM_DEPTH);

    state_e               state_q, state_d;
    logic                 run_q;
    logic [PW-1:0]        fptr_q, wptr_q;
    logic [INSTR_W-1:0]   instr_q, imem_rd;
    logic [FIELD_W-1:0]   wcnt_q, offset_q, synchro_q, operand;
    logic                 pend_q, wrap;
    logic [CW-1:0]        cnt;
    logic [CW:0]          at_sum, at_red;
    logic                 at_hit, exec_go, move_we, dirq_hit;
    opcode_e              op;

    fs_frame_ctr #(.FRAME_LEN(FRAME_LEN), .CW(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .adv(clk_en && qtick), .cnt(cnt), .wrap(wrap)
    );

    fs_imem #(.DEPTH(IMEM_DEPTH), .W(INSTR_W), .AW(PW)) u_imem (
        .clk(clk), .wr_en(push_valid && !rewind && !soft_rst),
        .wr_addr(wptr_q), .wr_data(push_word),
        .rd_addr(fptr_q), .rd_data(imem_rd)
    );

    assign op       = opcode_e'(instr_q[INSTR_W-1:OPC_LSB]);
    assign operand  = instr_q[FIELD_W-1:0];
    assign exec_go  = clk_en && !soft_rst && state_q == ST_EXEC;
    assign move_we  = exec_go && op == OP_MOVE;
    assign dirq_hit = move_we && instr_q[RADDR_W-1:0] == DIRQ_ADDR && instr_q[DATA_LSB];

    // frame position seen by the hold: (counter + offset) reduced once
    assign at_sum = {1'b0, cnt} + (CW+1)'(offset_q);
    assign at_red = (at_sum >= (CW+1)'(FRAME_LEN)) ? at_sum - (CW+1)'(FRAME_LEN) : at_sum;
    assign at_hit = at_red[CW-1:0] == CW'(operand);

    fs_regfile #(.NREG(NUM_REGS), .DW(DATA_W), .AW(RADDR_W),
                 .ACT_LO(ACT_LO), .ACT_HI(ACT_HI)) u_regs (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .we(move_we), .waddr(instr_q[RADDR_W-1:0]),
        .wdata(instr_q[DATA_LSB+DATA_W-1:DATA_LSB]),
        .raddr(rd_addr), .rdata(rd_data), .act_out(act_out)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= ST_IDLE;
        else if (soft_rst) state_q <= ST_IDLE;
        else if (clk_en)   state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run_q) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_EXEC;
            ST_EXEC: begin
                unique case (op)
                    OP_HALT:  state_d = ST_IDLE;
                    OP_AT:    state_d = at_hit ? ST_FETCH : ST_AT_HOLD;
                    OP_PAUSE: state_d = (operand == '0) ? ST_FETCH : ST_TICK_HOLD;
                    default:  state_d = ST_FETCH;
                endcase
            end
            ST_AT_HOLD:   if (at_hit) state_d = ST_FETCH;
            ST_TICK_HOLD: if (qtick && wcnt_q == FIELD_W'(1)) state_d = ST_FETCH;
            default:      state_d = ST_IDLE;
        endcase
        if (!run_q) state_d = ST_IDLE;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            fptr_q    <= '0;
            wptr_q    <= '0;
            instr_q   <= '0;
            wcnt_q    <= '0;
            offset_q  <= '0;
            synchro_q <= '0;
            pend_q    <= 1'b0;
        end else if (soft_rst) begin
            run_q     <= 1'b0;
            fptr_q    <= '0;
            wptr_q    <= '0;
            instr_q   <= '0;
            wcnt_q    <= '0;
            offset_q  <= '0;
            synchro_q <= '0;
            pend_q    <= 1'b0;
        end else begin
            if (en_clr)                        run_q <= 1'b0;
            else if (en_set)                   run_q <= 1'b1;
            else if (exec_go && op == OP_HALT) run_q <= 1'b0;

            if (rewind) begin
                fptr_q <= '0;
                wptr_q <= '0;
            end else begin
                if (push_valid) wptr_q <= wptr_q + 1'b1;
                if (clk_en && state_q == ST_FETCH) fptr_q <= fptr_q + 1'b1;
            end

            if (clk_en && state_q == ST_FETCH) instr_q <= imem_rd;

            if (exec_go && op == OP_PAUSE)
                wcnt_q <= operand;
            else if (clk_en && qtick && state_q == ST_TICK_HOLD)
                wcnt_q <= wcnt_q - 1'b1;

            if (exec_go && op == OP_OFFSET) offset_q  <= operand;
            if (exec_go && op == OP_SYNC)   synchro_q <= operand;

            if (dsp_irq_force || dirq_hit || (wrap && dsp_irq_en)) pend_q <= 1'b1;
            else if (dsp_irq_ack)                                  pend_q <= 1'b0;
        end
    end

    assign frame_count   = 13'(cnt);
    assign offset_val    = offset_q;
    assign synchro_val   = synchro_q;
    assign dsp_irq_pend  = pend_q;
    assign mcu_frame_irq = wrap && mcu_irq_en;
    assign idle          = state_q == ST_IDLE;

    assert_halt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_go && op == OP_HALT && !en_set) |=> (idle && !run_q));
    assert_pend_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !dsp_irq_ack && !soft_rst) |=> pend_q);
    assert_mcu_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mcu_frame_irq |-> frame_count == '0);
    assert_tick_cnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TICK_HOLD) |-> wcnt_q != '0);
endmodule

// File: tb/frame_seq_tb.sv
module frame_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 0, clk_en = 1, qtick = 1, push_valid = 0, rewind = 0;
    logic [15:0] push_word = '0;
    logic        en_set = 0, en_clr = 0, mcu_irq_en = 0, dsp_irq_en = 0;
    logic        dsp_irq_force = 0, dsp_irq_ack = 0;
    logic [4:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [12:0] frame_count, offset_val, synchro_val;
    logic [15:0] act_out;
    logic        dsp_irq_pend, mcu_frame_irq, idle;

    int n_chk = 0, n_fail = 0;
    logic [15:0] prog [64];

    always #5 clk = ~clk;

    frame_seq u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clk_en(clk_en), .qtick(qtick),
        .push_valid(push_valid), .push_word(push_word), .rewind(rewind),
        .en_set(en_set), .en_clr(en_clr), .mcu_irq_en(mcu_irq_en), .dsp_irq_en(dsp_irq_en),
        .dsp_irq_force(dsp_irq_force), .dsp_irq_ack(dsp_irq_ack), .rd_addr(rd_addr),
        .rd_data(rd_data), .frame_count(frame_count), .offset_val(offset_val),
        .synchro_val(synchro_val), .act_out(act_out), .dsp_irq_pend(dsp_irq_pend),
        .mcu_frame_irq(mcu_frame_irq), .idle(idle)
    );

    function automatic logic [15:0] enc(input int opc, input int opnd);
        return {3'(opc), 13'(opnd)};
    endfunction
    function automatic logic [15:0] mv(input int addr, input int data);
        return {3'd4, 8'(data), 5'(addr)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int n);
        @(negedge clk); rewind = 1;
        @(negedge clk); rewind = 0;
        for (int i = 0; i < n; i++) begin
            push_valid = 1; push_word = prog[i];
            @(negedge clk);
        end
        push_valid = 0;
    endtask

    task automatic run_wait();
        en_set = 1; @(negedge clk); en_set = 0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 20000 && !idle; i++) @(negedge clk);
        check("R8 idle reached", int'(idle), 1);
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = 5'(a); #1; v = int'(rd_data);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int v, f0, cyc, off, tt, expf;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 idle", int'(idle), 1);
        check("R1 frame_count", int'(frame_count), 0);
        check("R1 offset", int'(offset_val), 0);
        check("R1 synchro", int'(synchro_val), 0);
        check("R1 act_out", int'(act_out), 0);
        check("R1 pend", int'(dsp_irq_pend), 0);
        check("R1 mcu irq", int'(mcu_frame_irq), 0);

        // R2 counting, hold with clk_en low
        f0 = int'(frame_count);
        repeat (10) @(negedge clk);
        check("R2 advance", int'(frame_count), (f0 + 10) % 5000);
        clk_en = 0; f0 = int'(frame_count);
        repeat (5) @(negedge clk);
        check("R2 hold", int'(frame_count), f0);
        clk_en = 1;

        // R3 offset / synchro sweep
        for (int i = 1; i <= 4; i++) begin
            prog[0] = enc(2, (i * 613) % 5000);
            prog[1] = enc(3, (i * 1931 + 7) % 8192);
            prog[2] = enc(0, 0);
            load(3); run_wait();
            check("R3 offset", int'(offset_val), (i * 613) % 5000);
            check("R3 synchro", int'(synchro_val), (i * 1931 + 7) % 8192);
        end

        // R4 register writes to all 16 addresses
        for (int a = 0; a < 16; a++) prog[a] = mv(a, (a * 37 + 5) & 255);
        prog[16] = enc(0, 0);
        load(17); run_wait();
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            check("R4 readback", v, (a * 37 + 5) & 255);
        end
        check("R4 act_out", int'(act_out), (((7 * 37 + 5) & 255) << 8) | ((6 * 37 + 5) & 255));

        // R5 interrupt address and ignored addresses
        prog[0] = mv(16, 0); prog[1] = mv(17, 255); prog[2] = mv(31, 255); prog[3] = enc(0, 0);
        load(4); run_wait();
        check("R5 data bit0 clear", int'(dsp_irq_pend), 0);
        rd(17, v); check("R5 read 0x11", v, 0);
        rd(31, v); check("R5 read 0x1F", v, 0);
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            check("R5 regs untouched", v, (a * 37 + 5) & 255);
        end
        prog[0] = mv(16, 1); prog[1] = enc(0, 0);
        load(2); run_wait();
        check("R5 raise pend", int'(dsp_irq_pend), 1);
        dsp_irq_ack = 1; @(negedge clk); dsp_irq_ack = 0;
        check("R11 ack clears", int'(dsp_irq_pend), 0);

        // R6 hold-until-time sweep
        for (int i = 0; i < 6; i++) begin
            off = (i * 1777) % 5000;
            tt  = (i * 2903 + 11) % 5000;
            prog[0] = enc(2, off); prog[1] = enc(1, tt);
            prog[2] = mv(6, 8'h40 + i); prog[3] = enc(0, 0);
            load(4);
            en_set = 1; @(negedge clk); en_set = 0;
            for (int k = 0; k < 12000 && act_out[7:0] != 8'(8'h40 + i); k++) @(negedge clk);
            expf = ((tt - off + 5000) % 5000 + 3) % 5000;
            check("R6 release time", int'(frame_count), expf);
            repeat (6) @(negedge clk);
        end

        // R7 pause sweep
        for (int i = 0; i < 6; i++) begin
            int n;
            n = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 2 : (i == 3) ? 5 : (i == 4) ? 17 : 100;
            prog[0] = mv(6, 8'h10 + i); prog[1] = enc(5, n);
            prog[2] = mv(6, 8'h80 + i); prog[3] = enc(0, 0);
            load(4);
            en_set = 1; @(negedge clk); en_set = 0;
            for (int k = 0; k < 200 && act_out[7:0] != 8'(8'h10 + i); k++) @(negedge clk);
            cyc = 0;
            for (int k = 0; k < 300 && act_out[7:0] != 8'(8'h80 + i); k++) begin
                @(negedge clk); cyc++;
            end
            check("R7 pause length", cyc, n + 4);
            repeat (4) @(negedge clk);
        end

        // R8 halt then resume, R10 rewind
        prog[0] = enc(2, 10); prog[1] = enc(0, 0); prog[2] = enc(2, 20); prog[3] = enc(0, 0);
        load(4); run_wait();
        repeat (10) @(negedge clk);
        check("R8 stopped", int'(offset_val), 10);
        check("R8 idle held", int'(idle), 1);
        run_wait();
        check("R8 resume next word", int'(offset_val), 20);
        @(negedge clk); rewind = 1; @(negedge clk); rewind = 0;
        run_wait();
        check("R10 rerun from base", int'(offset_val), 10);

        // R9 reserved opcodes
        prog[0] = enc(2, 100); prog[1] = 16'hC123; prog[2] = 16'hE456;
        prog[3] = enc(3, 55); prog[4] = enc(0, 0);
        load(5); run_wait();
        check("R9 offset kept", int'(offset_val), 100);
        check("R9 synchro", int'(synchro_val), 55);
        rd(3, v); check("R9 reg3 kept", v, (3 * 37 + 5) & 255);
        check("R9 pend kept", int'(dsp_irq_pend), 0);

        // R11 interrupts
        dsp_irq_force = 1; @(negedge clk); dsp_irq_force = 0;
        check("R11 force", int'(dsp_irq_pend), 1);
        repeat (20) @(negedge clk);
        check("R11 hold", int'(dsp_irq_pend), 1);
        dsp_irq_ack = 1; @(negedge clk); dsp_irq_ack = 0;
        check("R11 ack", int'(dsp_irq_pend), 0);
        for (int k = 0; k < 6000 && frame_count != 13'd4999; k++) @(negedge clk);
        @(negedge clk);
        check("R11 no mcu pulse disabled", int'(mcu_frame_irq), 0);
        check("R2 wrap to 0", int'(frame_count), 0);
        mcu_irq_en = 1; dsp_irq_en = 1;
        for (int k = 0; k < 6000 && frame_count != 13'd4999; k++) @(negedge clk);
        @(negedge clk);
        check("R11 mcu pulse", int'(mcu_frame_irq), 1);
        check("R11 count at pulse", int'(frame_count), 0);
        @(negedge clk);
        check("R11 mcu one cycle", int'(mcu_frame_irq), 0);
        check("R11 dsp pend at wrap", int'(dsp_irq_pend), 1);
        mcu_irq_en = 0; dsp_irq_en = 0;
        dsp_irq_ack = 1; @(negedge clk); dsp_irq_ack = 0;

        // R12 soft reset keeps program
        prog[0] = enc(2, 4321); prog[1] = mv(7, 8'h5A); prog[2] = enc(0, 0);
        load(3); run_wait();
        check("R12 before", int'(offset_val), 4321);
        dsp_irq_force = 1; @(negedge clk); dsp_irq_force = 0;
        soft_rst = 1; @(negedge clk);
        check("R12 count", int'(frame_count), 0);
        check("R12 offset", int'(offset_val), 0);
        check("R12 act_out", int'(act_out), 0);
        check("R12 pend", int'(dsp_irq_pend), 0);
        check("R12 idle", int'(idle), 1);
        soft_rst = 0; @(negedge clk);
        run_wait();
        check("R12 rerun offset", int'(offset_val), 4321);
        check("R12 rerun act", int'(act_out), 16'h5A00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule